// File: doc/BRIEF.md
# Saturating Arithmetic Unit with Sticky Flag

This block performs 32-bit arithmetic that clamps to the representable range instead of wrapping. It offers signed and unsigned add and subtract with saturation, a signed add that wraps but still reports overflow, and saturation of a signed value to a chosen bit position. The saturation-to-position step is available in a signed or unsigned flavour, on the whole word or on two packed 16-bit halves at once.

A caller presents an opcode, two operands and a bit position together with a one-cycle start strobe. One clock later the registered result appears with a one-cycle done pulse. Every operation that clamps sets a sticky saturation flag. The flag stays set until a separate clear strobe or reset, so software-visible logic can check one flag after a long run of operations.

Top module: `sat_alu_unit`

## Requirements
- R1: Opcode 0 (signed add) returns a+b. When both operands share a sign and the sum's sign differs, it returns 0x7FFFFFFF if a is non-negative and 0x80000000 otherwise, and it saturates.
- R2: Opcode 1 (signed subtract) returns a-b. When the operands differ in sign and the difference's sign differs from a, it clamps exactly as R1 does and saturates.
- R3: Opcode 2 (unsigned add) returns a+b. A carry out of bit 31 clamps the result to 0xFFFFFFFF and saturates.
- R4: Opcode 3 (unsigned subtract) returns a-b. When b > a, the result clamps to 0 and saturates.
- R5: Opcode 4 (flagging add) always returns the wrapped a+b. It saturates, for the flag only, under the signed-overflow condition of R1.
- R6: Opcode 5 (signed clamp) treats a as signed and uses s = pos (0..31). It returns 2^s-1 when a > 2^s-1 and -2^s when a < -2^s, and saturates in both cases. Otherwise it returns a.
- R7: Opcode 6 (unsigned clamp) treats a as signed and uses s = pos. It returns 0 for negative a and 2^s-1 for a > 2^s-1, and saturates in both cases. Otherwise it returns a.
- R8: Opcode 7 sign-extends a[15:0] and a[31:16] separately and applies R6 to each. It packs the low 16 bits of each result back into its own half, and saturates if either half clamps.
- R9: Opcode 8 does the same as R8, applying R7 to each sign-extended half.
- R10: The sticky flag is set by any started operation that saturates and is otherwise kept. The clear strobe drops it to 0, except when a saturating operation starts in the same cycle, in which case it becomes 1.
- R11: Result and done update on the first clock edge after a start. Done is high for exactly that one cycle. Without start, the result holds its value.
- R12: Opcodes 9 to 15 return 0 and leave the flag unchanged.
- R13: After reset, result, done and the flag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Starts the operation selected by op |
| clr_flag | input | 1 | Clears the sticky saturation flag |
| op | input | 4 | Operation code |
| a | input | 32 | First operand / value to clamp |
| b | input | 32 | Second operand |
| pos | input | 5 | Saturation bit position s |
| result | output | 32 | Registered result |
| done | output | 1 | One-cycle pulse when result is new |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
Directed patterns drive each overflow rule at its edge: sums exactly at and one past the signed limits, an unsigned carry from 0xFFFFFFFF+1, a borrow by one, and clamps at positions 0, 15 and 31. These separate the boundary from the first clamping value. Halfword cases put a clamping value in one half only, which shows whether the halves are handled independently and whether a clamp in either half alone raises the flag. Random operands, opcodes, positions and clear strobes from a fixed seed mix saturating and non-saturating operations with clears, including clears in the same cycle as a saturation. A bench model predicts the value of the sticky flag against these.

// File: rtl/sat_alu_pkg.sv
package sat_alu_pkg;
  typedef enum logic [3:0] {
    OP_SADD   = 4'd0,
    OP_SSUB   = 4'd1,
    OP_UADD   = 4'd2,
    OP_USUB   = 4'd3,
    OP_QADD   = 4'd4,
    OP_SCLAMP = 4'd5,
    OP_UCLAMP = 4'd6,
    OP_SCLP16 = 4'd7,
    OP_UCLP16 = 4'd8
  } sat_op_e;
endpackage

// File: rtl/sat_rst_sync.sv
module sat_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/sat_addsub.sv
module sat_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         is_sub,
  input  logic         is_signed,
  input  logic         clamp_en,
  output logic [W-1:0] res,
  output logic         ovf
);
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic [W:0]   wide;
  logic [W-1:0] raw;
  logic         s_ovf;
  logic         u_ovf;
  logic [W-1:0] limit;

  always_comb begin
    wide  = is_sub ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
    raw   = wide[W-1:0];
    if (is_sub) s_ovf = (a[W-1] ^ b[W-1]) & (raw[W-1] ^ a[W-1]);
    else        s_ovf = ~(a[W-1] ^ b[W-1]) & (raw[W-1] ^ a[W-1]);
    u_ovf = wide[W];
    ovf   = is_signed ? s_ovf : u_ovf;
    if (is_signed)   limit = a[W-1] ? SMIN : SMAX;
    else if (is_sub) limit = '0;
    else             limit = '1;
    res   = (clamp_en && ovf) ? limit : raw;
  end
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
  parameter int W  = 32,
  parameter int PW = $clog2(W)
) (
  input  logic [W-1:0]  val,
  input  logic [PW-1:0] pos,
  input  logic          is_signed,
  output logic [W-1:0]  res,
  output logic          hit
);
  logic [W-1:0]        mask;
  logic signed [W-1:0] top;

  always_comb begin
    mask = ({{(W-1){1'b0}}, 1'b1} << pos) - 1'b1;
    top  = $signed(val) >>> pos;
    res  = val;
    hit  = 1'b0;
    if (is_signed) begin
      if (top > 0) begin
        res = mask;  hit = 1'b1;
      end else if (top < -1) begin
        res = ~mask; hit = 1'b1;
      end
    end else begin
      if (val[W-1]) begin
        res = '0;    hit = 1'b1;
      end else if (val > mask) begin
        res = mask;  hit = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sat_alu_unit.sv
module sat_alu_unit
  import sat_alu_pkg::*;
#(
  parameter int W  = 32,
  parameter int PW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          clr_flag,
  input  logic [3:0]    op,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic [PW-1:0] pos,
  output logic [W-1:0]  result,
  output logic          done,
  output logic          sat_flag
);
  localparam int H = W / 2;

  logic rst_n_s;
  sat_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  sat_op_e op_e;
  assign op_e = sat_op_e'(op);

  // add / subtract path
  logic         as_sub, as_signed, as_clamp, as_ovf;
  logic [W-1:0] as_res;
  always_comb begin
    as_sub    = (op_e == OP_SSUB) || (op_e == OP_USUB);
    as_signed = (op_e == OP_SADD) || (op_e == OP_SSUB) || (op_e == OP_QADD);
    as_clamp  = (op_e != OP_QADD);
  end

  sat_addsub #(.W(W)) u_addsub (
    .a(a), .b(b), .is_sub(as_sub), .is_signed(as_signed),
    .clamp_en(as_clamp), .res(as_res), .ovf(as_ovf)
  );

  // clamp lanes: lane 0 = word, lanes 1/2 = low/high halfword
  logic          cl_signed;
  logic [W-1:0]  lane_in  [3];
  logic [W-1:0]  lane_res [3];
  logic [2:0]    lane_hit;

  assign cl_signed  = (op_e == OP_SCLAMP) || (op_e == OP_SCLP16);
  assign lane_in[0] = a;
  assign lane_in[1] = {{(W-H){a[H-1]}}, a[H-1:0]};
  assign lane_in[2] = {{(W-H){a[W-1]}}, a[W-1:H]};

  for (genvar g = 0; g < 3; g++) begin : g_lane
    sat_clamp #(.W(W), .PW(PW)) u_clamp (
      .val(lane_in[g]), .pos(pos), .is_signed(cl_signed),
      .res(lane_res[g]), .hit(lane_hit[g])
    );
  end

  // operation select
  logic [W-1:0] op_res;
  logic         op_hit;
  always_comb begin
    op_res = '0;
    op_hit = 1'b0;
    case (op_e)
      OP_SADD, OP_SSUB, OP_UADD, OP_USUB, OP_QADD: begin
        op_res = as_res;
        op_hit = as_ovf;
      end
      OP_SCLAMP, OP_UCLAMP: begin
        op_res = lane_res[0];
        op_hit = lane_hit[0];
      end
      OP_SCLP16, OP_UCLP16: begin
        op_res = {lane_res[2][H-1:0], lane_res[1][H-1:0]};
        op_hit = lane_hit[1] | lane_hit[2];
      end
      default: begin
        op_res = '0;
        op_hit = 1'b0;
      end
    endcase
  end

  // next state
  logic         set_flag;
  logic [W-1:0] result_d;
  logic         done_d, flag_d;
  always_comb begin
    set_flag = start & op_hit;
    result_d = start ? op_res : result;
    done_d   = start;
    if (set_flag)      flag_d = 1'b1;
    else if (clr_flag) flag_d = 1'b0;
    else               flag_d = sat_flag;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      result   <= '0;
      done     <= 1'b0;
      sat_flag <= 1'b0;
    end else begin
      result   <= result_d;
      done     <= done_d;
      sat_flag <= flag_d;
    end
  end

  a_r11_done_after_start: assert property (@(posedge clk) disable iff (!rst_n_s)
    start |=> done);
  a_r11_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n_s)
    !start |=> !done);
  a_r11_result_held: assert property (@(posedge clk) disable iff (!rst_n_s)
    !start |=> $stable(result));
  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n_s)
    (sat_flag && !clr_flag) |=> sat_flag);
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n_s)
    (start && op_hit) |=> sat_flag);
  a_r3_uadd_floor: assert property (@(posedge clk) disable iff (!rst_n_s)
    (start && op == 4'd2) |=> (result >= $past(a)));
  a_r4_usub_ceiling: assert property (@(posedge clk) disable iff (!rst_n_s)
    (start && op == 4'd3) |=> (result <= $past(a)));
endmodule

// File: tb/sat_alu_unit_tb_top.sv
module sat_alu_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        clr_flag = 1'b0;
  logic [3:0]  op = '0;
  logic [31:0] a = '0;
  logic [31:0] b = '0;
  logic [4:0]  pos = '0;
  logic [31:0] result;
  logic        done;
  logic        sat_flag;

  int checks = 0;
  int fails  = 0;
  bit exp_flag = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sat_alu_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .clr_flag(clr_flag),
    .op(op), .a(a), .b(b), .pos(pos),
    .result(result), .done(done), .sat_flag(sat_flag)
  );

  function automatic bit [32:0] clamp_ref(input logic [31:0] v, input int s, input bit sgn);
    longint val, hi, lo;
    val = longint'($signed(v));
    hi  = (longint'(1) <<< s) - 1;
    lo  = -(longint'(1) <<< s);
    if (sgn) begin
      if (val > hi) return {1'b1, hi[31:0]};
      if (val < lo) return {1'b1, lo[31:0]};
    end else begin
      if (val < 0)  return {1'b1, 32'd0};
      if (val > hi) return {1'b1, hi[31:0]};
    end
    return {1'b0, v};
  endfunction

  // returns {saturated, result}
  function automatic bit [32:0] model(input logic [3:0] o, input logic [31:0] x,
                                      input logic [31:0] y, input int s);
    longint sx, sy, r;
    bit [32:0] u, lo16, hi16;
    sx = longint'($signed(x));
    sy = longint'($signed(y));
    case (o)
      4'd0, 4'd4: begin
        r = sx + sy;
        if (r > 64'sh7FFFFFFF || r < -64'sh80000000)
          return {1'b1, (o == 4'd4) ? (x + y) : (sx < 0 ? 32'h80000000 : 32'h7FFFFFFF)};
        return {1'b0, x + y};
      end
      4'd1: begin
        r = sx - sy;
        if (r > 64'sh7FFFFFFF || r < -64'sh80000000)
          return {1'b1, sx < 0 ? 32'h80000000 : 32'h7FFFFFFF};
        return {1'b0, x - y};
      end
      4'd2: begin
        u = {1'b0, x} + {1'b0, y};
        return u[32] ? {1'b1, 32'hFFFFFFFF} : {1'b0, u[31:0]};
      end
      4'd3: return (y > x) ? {1'b1, 32'd0} : {1'b0, x - y};
      4'd5: return clamp_ref(x, s, 1'b1);
      4'd6: return clamp_ref(x, s, 1'b0);
      4'd7, 4'd8: begin
        lo16 = clamp_ref({{16{x[15]}}, x[15:0]}, s, o == 4'd7);
        hi16 = clamp_ref({{16{x[31]}}, x[31:16]}, s, o == 4'd7);
        return {lo16[32] | hi16[32], hi16[15:0], lo16[15:0]};
      end
      default: return {1'b0, 32'd0};
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd0: return "R1";  4'd1: return "R2";  4'd2: return "R3";
      4'd3: return "R4";  4'd4: return "R5";  4'd5: return "R6";
      4'd6: return "R7";  4'd7: return "R8";  4'd8: return "R9";
      default: return "R12";
    endcase
  endfunction

  task automatic run_op(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                        input int s, input bit clr);
    bit [32:0] m;
    @(negedge clk);
    op = o; a = x; b = y; pos = 5'(s); start = 1'b1; clr_flag = clr;
    m = model(o, x, y, s);
    if (m[32])   exp_flag = 1'b1;
    else if (clr) exp_flag = 1'b0;
    @(negedge clk);
    start = 1'b0; clr_flag = 1'b0;
    check(tag_of(o), result, m[31:0]);
    check("R11 done", {31'd0, done}, 32'd1);
    check("R10 flag", {31'd0, sat_flag}, {31'd0, exp_flag});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] held;
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R13 reset state
    check("R13 result", result, 32'd0);
    check("R13 done", {31'd0, done}, 32'd0);
    check("R13 flag", {31'd0, sat_flag}, 32'd0);

    // R1 boundaries
    run_op(4'd0, 32'h7FFFFFFE, 32'd1, 0, 0);
    run_op(4'd0, 32'h7FFFFFFF, 32'd1, 0, 0);
    run_op(4'd0, 32'h80000000, 32'hFFFFFFFF, 0, 1);
    // R10 clear alone, then no-saturation keep
    run_op(4'd2, 32'd1, 32'd2, 0, 1);
    run_op(4'd0, 32'h80000000, 32'd0, 0, 0);
    // R2
    run_op(4'd1, 32'h80000000, 32'd1, 0, 0);
    run_op(4'd1, 32'h7FFFFFFF, 32'hFFFFFFFF, 0, 1);
    run_op(4'd1, 32'd5, 32'd9, 0, 1);
    // R3, R4
    run_op(4'd2, 32'hFFFFFFFF, 32'd1, 0, 0);
    run_op(4'd2, 32'hFFFFFFFE, 32'd1, 0, 1);
    run_op(4'd3, 32'd4, 32'd5, 0, 0);
    run_op(4'd3, 32'd5, 32'd5, 0, 1);
    // R5 wrap plus flag
    run_op(4'd4, 32'h7FFFFFFF, 32'd1, 0, 0);
    // R6, R7 positions
    run_op(4'd5, 32'd256, 32'd0, 8, 1);
    run_op(4'd5, 32'd255, 32'd0, 8, 1);
    run_op(4'd5, 32'hFFFFFF00, 32'd0, 8, 1);
    run_op(4'd5, 32'hFFFFFEFF, 32'd0, 8, 1);
    run_op(4'd5, 32'd3, 32'd0, 0, 1);
    run_op(4'd5, 32'h80000000, 32'd0, 31, 1);
    run_op(4'd6, 32'hFFFFFFFF, 32'd0, 4, 1);
    run_op(4'd6, 32'd16, 32'd0, 4, 1);
    run_op(4'd6, 32'd15, 32'd0, 4, 1);
    run_op(4'd6, 32'h7FFFFFFF, 32'd0, 31, 1);
    // R8, R9 one half clamps
    run_op(4'd7, 32'h0005_7FFF, 32'd0, 8, 1);
    run_op(4'd7, 32'h8000_0010, 32'd0, 15, 1);
    run_op(4'd7, 32'h1234_8000, 32'd0, 16, 1);
    run_op(4'd8, 32'h0003_FFFF, 32'd0, 4, 1);
    run_op(4'd8, 32'h0100_0007, 32'd0, 4, 1);
    // R12 unused opcodes
    run_op(4'd2, 32'hFFFFFFFF, 32'd5, 0, 0);
    run_op(4'd9, 32'hFFFFFFFF, 32'd5, 0, 0);
    run_op(4'd15, 32'h1, 32'h1, 0, 0);

    // R11 done is a single pulse, result held without start
    held = result;
    @(negedge clk);
    check("R11 done pulse", {31'd0, done}, 32'd0);
    a = 32'hDEADBEEF; op = 4'd2;
    @(negedge clk);
    check("R11 held", result, held);

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [3:0]  ro;
      logic [31:0] ra, rb;
      ro = 4'($urandom % 10);
      ra = $urandom;
      rb = $urandom;
      if ($urandom % 4 == 0) ra = {ra[31], {31{~ra[31]}}};
      run_op(ro, ra, rb, int'($urandom % 32), ($urandom % 5) == 0);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule